// File: doc/BRIEF.md
# Maskable Interrupt Priority Controller

This block collects up to `N_SRC` maskable interrupt sources and presents a single winning request to the processor. Each source holds a pending flag and a 3-bit priority level. A peripheral sets the pending flag with a one-cycle pulse. Software can rewrite the level through a write port. Through the same port, software may clear the pending flag but can never set it.

Every cycle, the block selects among the pending sources. A source is eligible only when three conditions hold: the global enable input is high, its level is nonzero, and its level is strictly above the current processor priority input. The highest level wins, and a tie goes to the lowest index. The result is registered and shown on `irq_valid_o`, `irq_idx_o` and `irq_lvl_o`.

The processor accepts the request with a one-cycle `ack_i` pulse. The block then reports the accepted index and level for one cycle and clears that source's pending flag.

Top module: `irq_prio_ctrl`

## Requirements
- R1: The level field is 3 bits wide, with 7 the most urgent. A source whose level is 0 is never forwarded, even when it is pending and the processor priority is 0.
- R2: When `ien_i` is 0, `irq_valid_o` is 0 in the following cycle, whatever the pending flags and levels.
- R3: A one-cycle `req_pulse_i[i]` sets pending flag i. The flag is visible on `req_pend_o[i]` after the next clock edge.
- R4: A write (`wr_en_i`=1, `wr_req_i`=0) clears the pending flag of source `wr_idx_i`. A write with `wr_req_i`=1 leaves the flag unchanged. Both writes load `wr_lvl_i` as the new level.
- R5: A pending source is forwarded only if its level is strictly greater than `ipl_i`. With `ipl_i`=7, nothing is forwarded. With `ipl_i`=n, only levels n+1 to 7 are forwarded.
- R6: Among eligible sources, the highest level wins. Among equal levels, the lowest index wins.
- R7: The winner outputs are registered. A pulse at clock edge k shows on `req_pend_o` after edge k and on `irq_valid_o` after edge k+1.
- R8: A hardware pulse to source i takes precedence over a software clear or an acknowledge clear of source i in the same cycle. The flag is 1 afterwards.
- R9: An acknowledge works as follows. If `ack_i`=1 while `irq_valid_o`=1, then in the next cycle `ack_valid_o`=1 for exactly one cycle, with the winner's index and level, `irq_valid_o`=0, and the winner's pending flag cleared. An `ack_i` pulse while `irq_valid_o`=0 has no effect.
- R10: Pending flags, levels, `ien_i` and `ipl_i` are independent. A level write does not change any flag. Changing `ien_i` or `ipl_i` does not change any flag or level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_pulse_i | input | N_SRC | Hardware request pulses, one per source |
| wr_en_i | input | 1 | Control register write strobe |
| wr_idx_i | input | IDX_W | Source index of the write |
| wr_req_i | input | 1 | Pending-flag value of the write (0 clears, 1 no effect) |
| wr_lvl_i | input | 3 | Level value of the write |
| ien_i | input | 1 | Global maskable interrupt enable |
| ipl_i | input | 3 | Current processor priority level |
| ack_i | input | 1 | Acknowledge pulse from the processor |
| req_pend_o | output | N_SRC | Pending flags |
| irq_valid_o | output | 1 | An eligible request is presented |
| irq_idx_o | output | IDX_W | Index of the presented request |
| irq_lvl_o | output | 3 | Level of the presented request |
| ack_valid_o | output | 1 | One-cycle acknowledge result strobe |
| ack_idx_o | output | IDX_W | Index of the accepted request |
| ack_lvl_o | output | 3 | Level of the accepted request |

## Verification
The acknowledge properties assume that `ack_i` is a pulse raised only while a request is presented. The bench acknowledges once per presentation and issues one deliberate stray pulse while `irq_valid_o` is low. The level-stability and pending-flag properties assume that `ien_i`, `ipl_i` and the write port change only between clock edges. The bench drives every input on the falling edge and holds each write for a single cycle. Request pulses are one cycle wide. When a pulse collides with a clear, it is placed in exactly the cycle of that clear.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned LVL_W = 3;
  typedef logic [LVL_W-1:0] lvl_t;
  localparam lvl_t LVL_OFF = '0;
endpackage

// File: rtl/irq_src_slot.sv
module irq_src_slot
  import irq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hw_set_i,
  input  logic sw_we_i,
  input  logic sw_req_i,
  input  lvl_t sw_lvl_i,
  input  logic ack_clr_i,
  output logic pend_o,
  output lvl_t lvl_o
);

  logic clr;
  assign clr = (sw_we_i && !sw_req_i) || ack_clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= 1'b0;
    end else if (hw_set_i) begin
      pend_o <= 1'b1;           // set beats any clear
    end else if (clr) begin
      pend_o <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lvl_o <= LVL_OFF;
    else if (sw_we_i) lvl_o <= sw_lvl_i;
  end

  p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_set_i |=> pend_o);
  p_no_sw_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_o) |-> $past(hw_set_i));
  p_sw_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_we_i && !sw_req_i && !hw_set_i) |=> !pend_o);
  p_lvl_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sw_we_i |=> $stable(lvl_o));

endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_pkg::*;
#(
  parameter int unsigned N_SRC = 8,
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0]       pend_i,
  input  lvl_t [N_SRC-1:0]       lvl_i,
  input  logic                   ien_i,
  input  lvl_t                   ipl_i,
  output logic                   hit_o,
  output logic [IDX_W-1:0]       idx_o,
  output lvl_t                   lvl_o
);

  logic [N_SRC-1:0] elig;

  for (genvar g = 0; g < N_SRC; g++) begin : g_elig
    // strict compare also excludes level 0
    assign elig[g] = pend_i[g] && ien_i && (lvl_i[g] > ipl_i);
  end

  // ascending scan, strict '>' keeps the lowest index on ties
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    lvl_o = LVL_OFF;
    for (int i = 0; i < N_SRC; i++) begin
      if (elig[i] && (!hit_o || (lvl_i[i] > lvl_o))) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(i);
        lvl_o = lvl_i[i];
      end
    end
  end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned N_SRC = 8,
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] req_pulse_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_req_i,
  input  logic [LVL_W-1:0] wr_lvl_i,
  input  logic             ien_i,
  input  logic [LVL_W-1:0] ipl_i,
  input  logic             ack_i,
  output logic [N_SRC-1:0] req_pend_o,
  output logic             irq_valid_o,
  output logic [IDX_W-1:0] irq_idx_o,
  output logic [LVL_W-1:0] irq_lvl_o,
  output logic             ack_valid_o,
  output logic [IDX_W-1:0] ack_idx_o,
  output logic [LVL_W-1:0] ack_lvl_o
);

  lvl_t [N_SRC-1:0] lvl;
  logic [N_SRC-1:0] pend;
  logic             pick_hit;
  logic [IDX_W-1:0] pick_idx;
  lvl_t             pick_lvl;
  logic             ack_take;

  assign ack_take   = ack_i && irq_valid_o;
  assign req_pend_o = pend;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    logic we, clr;
    assign we  = wr_en_i && (wr_idx_i == IDX_W'(g));
    assign clr = ack_take && (irq_idx_o == IDX_W'(g));

    irq_src_slot u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .hw_set_i  (req_pulse_i[g]),
      .sw_we_i   (we),
      .sw_req_i  (wr_req_i),
      .sw_lvl_i  (wr_lvl_i),
      .ack_clr_i (clr),
      .pend_o    (pend[g]),
      .lvl_o     (lvl[g])
    );
  end

  irq_pick #(.N_SRC(N_SRC)) u_pick (
    .pend_i (pend),
    .lvl_i  (lvl),
    .ien_i  (ien_i),
    .ipl_i  (ipl_i),
    .hit_o  (pick_hit),
    .idx_o  (pick_idx),
    .lvl_o  (pick_lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_valid_o <= 1'b0;
      irq_idx_o   <= '0;
      irq_lvl_o   <= '0;
    end else begin
      // drop valid for one cycle after an accept: no double acknowledge
      irq_valid_o <= pick_hit && !ack_take;
      irq_idx_o   <= pick_idx;
      irq_lvl_o   <= pick_lvl;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_valid_o <= 1'b0;
      ack_idx_o   <= '0;
      ack_lvl_o   <= '0;
    end else begin
      ack_valid_o <= ack_take;
      if (ack_take) begin
        ack_idx_o <= irq_idx_o;
        ack_lvl_o <= irq_lvl_o;
      end
    end
  end

  p_ien_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o |-> $past(ien_i));
  p_strict_above_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o |-> (irq_lvl_o > $past(ipl_i)));
  p_lvl_nonzero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o |-> (irq_lvl_o != '0));
  p_ack_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_valid_o |=> !ack_valid_o);
  p_ack_drops_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_valid_o |-> !irq_valid_o);
  p_ack_source_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_valid_o |-> ($past(ack_i) && $past(irq_valid_o)));
  p_ack_echo_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_valid_o |-> (ack_idx_o == $past(irq_idx_o) && ack_lvl_o == $past(irq_lvl_o)));

endmodule

// File: tb/irq_prio_ctrl_tb_top.sv
module irq_prio_ctrl_tb_top;
  localparam int N = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req_pulse = '0;
  logic          wr_en = 1'b0;
  logic [IW-1:0] wr_idx = '0;
  logic          wr_req = 1'b0;
  logic [2:0]    wr_lvl = '0;
  logic          ien = 1'b0;
  logic [2:0]    ipl = '0;
  logic          ack = 1'b0;
  logic [N-1:0]  req_pend;
  logic          irq_valid, ack_valid;
  logic [IW-1:0] irq_idx, ack_idx;
  logic [2:0]    irq_lvl, ack_lvl;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_prio_ctrl #(.N_SRC(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_pulse_i(req_pulse),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_req_i(wr_req), .wr_lvl_i(wr_lvl),
    .ien_i(ien), .ipl_i(ipl), .ack_i(ack),
    .req_pend_o(req_pend), .irq_valid_o(irq_valid), .irq_idx_o(irq_idx),
    .irq_lvl_o(irq_lvl), .ack_valid_o(ack_valid), .ack_idx_o(ack_idx),
    .ack_lvl_o(ack_lvl)
  );

  // default levels per source index 0..7
  localparam logic [2:0] LV [N] = '{3'd3, 3'd5, 3'd0, 3'd7, 3'd5, 3'd1, 3'd7, 3'd2};

  typedef struct packed {
    logic [7:0] mask;
    logic       en;
    logic [2:0] pl;
    logic       val;
    logic [2:0] idx;
    logic [2:0] lvl;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{8'h01, 1'b1, 3'd0, 1'b1, 3'd0, 3'd3},
    '{8'h01, 1'b1, 3'd3, 1'b0, 3'd0, 3'd0},
    '{8'h01, 1'b1, 3'd2, 1'b1, 3'd0, 3'd3},
    '{8'h04, 1'b1, 3'd0, 1'b0, 3'd0, 3'd0},
    '{8'h12, 1'b1, 3'd0, 1'b1, 3'd1, 3'd5},
    '{8'h48, 1'b1, 3'd6, 1'b1, 3'd3, 3'd7},
    '{8'h48, 1'b1, 3'd7, 1'b0, 3'd0, 3'd0},
    '{8'hFF, 1'b0, 3'd0, 1'b0, 3'd0, 3'd0},
    '{8'hFF, 1'b1, 3'd0, 1'b1, 3'd3, 3'd7},
    '{8'hB3, 1'b1, 3'd4, 1'b1, 3'd1, 3'd5},
    '{8'hA1, 1'b1, 3'd2, 1'b1, 3'd0, 3'd3},
    '{8'hA0, 1'b1, 3'd1, 1'b1, 3'd7, 3'd2},
    '{8'h20, 1'b1, 3'd0, 1'b1, 3'd5, 3'd1}
  };

  task automatic check(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(int idx, bit req, int lvl);
    wr_en = 1'b1; wr_idx = IW'(idx); wr_req = req; wr_lvl = 3'(lvl);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clear_all();
    for (int i = 0; i < N; i++) wr(i, 1'b0, int'(LV[i]));
  endtask

  task automatic pulse(logic [N-1:0] m);
    req_pulse = m;
    @(negedge clk);
    req_pulse = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    check("R7 reset irq_valid", int'(irq_valid), 0);
    check("R3 reset pend", int'(req_pend), 0);
    check("R9 reset ack_valid", int'(ack_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R1 R2 R3 R5 R6
    for (int v = 0; v < NV; v++) begin
      clear_all();
      ien = VECS[v].en; ipl = VECS[v].pl;
      pulse(VECS[v].mask);
      check($sformatf("R3 vec%0d pend", v), int'(req_pend), int'(VECS[v].mask));
      @(negedge clk);
      check($sformatf("R5 R6 vec%0d valid", v), int'(irq_valid), int'(VECS[v].val));
      if (VECS[v].val) begin
        check($sformatf("R6 vec%0d idx", v), int'(irq_idx), int'(VECS[v].idx));
        check($sformatf("R1 R6 vec%0d lvl", v), int'(irq_lvl), int'(VECS[v].lvl));
      end
    end

    // R7 latency
    clear_all();
    ien = 1'b1; ipl = 3'd0;
    @(negedge clk);
    pulse(8'h40);
    check("R7 pend after first edge", int'(req_pend[6]), 1);
    check("R7 valid not yet", int'(irq_valid), 0);
    @(negedge clk);
    check("R7 valid after second edge", int'(irq_valid), 1);

    // R4: write of 1 keeps a set flag and does not set a clear one
    clear_all();
    pulse(8'h01);
    wr(0, 1'b1, 3);
    check("R4 write1 keeps flag", int'(req_pend[0]), 1);
    wr(1, 1'b1, 5);
    check("R4 write1 no set", int'(req_pend[1]), 0);
    @(negedge clk);
    check("R4 write1 no request", int'(irq_idx), 0);
    wr(0, 1'b0, 3);
    check("R4 write0 clears", int'(req_pend[0]), 0);
    @(negedge clk);
    check("R4 cleared not forwarded", int'(irq_valid), 0);

    // R10: level rewrite keeps flag; ien/ipl toggles keep flags and levels
    pulse(8'h02);
    wr(1, 1'b1, 2);
    check("R10 level write keeps flag", int'(req_pend), 2);
    ien = 1'b0; ipl = 3'd7;
    @(negedge clk); @(negedge clk);
    check("R2 ien low blocks", int'(irq_valid), 0);
    check("R10 ien/ipl keep flag", int'(req_pend), 2);
    ien = 1'b1; ipl = 3'd0;
    @(negedge clk); @(negedge clk);
    check("R10 level kept", int'(irq_lvl), 2);
    check("R10 valid back", int'(irq_valid), 1);

    // R8: set and software clear in the same cycle
    clear_all();
    req_pulse = 8'h08; wr_en = 1'b1; wr_idx = 3'd3; wr_req = 1'b0; wr_lvl = 3'd7;
    @(negedge clk);
    req_pulse = '0; wr_en = 1'b0;
    check("R8 set beats sw clear", int'(req_pend[3]), 1);

    // R9: acknowledge with two pending
    clear_all();
    pulse(8'h0A);
    @(negedge clk);
    check("R9 winner idx", int'(irq_idx), 3);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    check("R9 ack_valid", int'(ack_valid), 1);
    check("R9 ack idx", int'(ack_idx), 3);
    check("R9 ack lvl", int'(ack_lvl), 7);
    check("R9 valid drops", int'(irq_valid), 0);
    check("R9 flag cleared", int'(req_pend), 2);
    @(negedge clk);
    check("R9 ack one cycle", int'(ack_valid), 0);
    check("R9 next winner idx", int'(irq_idx), 1);
    check("R9 next winner valid", int'(irq_valid), 1);

    // R8: set and ack clear in the same cycle
    pulse(8'h08);
    @(negedge clk);
    check("R8 winner before ack", int'(irq_idx), 3);
    ack = 1'b1; req_pulse = 8'h08;
    @(negedge clk);
    ack = 1'b0; req_pulse = '0;
    check("R8 ack reported", int'(ack_valid), 1);
    check("R8 set beats ack clear", int'(req_pend[3]), 1);

    // R9: stray ack ignored
    clear_all();
    @(negedge clk);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    check("R9 stray ack ignored", int'(ack_valid), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule